// File: doc/BRIEF.md
# Regulator Wake and Reset Sequencer

This block is the digital controller next to a low-drop supply regulator and a single-wire bus transceiver. It decides when the regulator is powered and drives the active-low reset of the attached microcontroller. The analog side arrives as already-digitised flags:
- a power-on comparator on the regulated rail;
- an undervoltage comparator for the threshold this block selected;
- the enable pin;
- the bus level;
- an over-temperature flag;
- the sensed level of a single programming pin.

A slow oscillator tick, one clock wide, paces every timer.

The regulator starts on a high enable level, on a qualified bus pulse while in standby, or on recovery from thermal shutdown. Once the rail passes its power-on threshold, the programming pin is read twice:
- Its static level picks the undervoltage threshold.
- A one-tick current pulse that opposes that level then shows whether a resistor or a hard rail holds the pin. A resistor gives the short reset delay and a hard rail gives the long one.

Reset is released when that delay has run out. It is pulled again when undervoltage persists for the reaction time.

Top module: `regwake_seq`

## Requirements
- R1: In standby with `ovt` low, `en` high powers the regulator (`reg_on`=1) on the next clock, and `reset_n` is 0 when it powers up.
- R2: On the first tick after power-up on which `vcc_por_ok` is 1, the pin level is latched into `vres_hi_sel`. A latched 1 selects the 4.65 V threshold and a latched 0 selects the 3.15 V threshold. The latched value changes at no other time.
- R3: From the sampling tick to the next tick, exactly one of `prog_pu` (latched level 0) or `prog_pd` (latched level 1) is high. Both are low otherwise.
- R4: At the pulse-end tick the pin is compared with the latched level. If it differs, the delay is `SHORT_TICKS`; otherwise it is `LONG_TICKS`. `reset_n` rises one clock after the tick that completes that many ticks from the sampling tick. Ticks during which `vcc_low` is high restart the wait. Both delays must be at least 2.
- R5: While reset is released, `vcc_low` must be high across `TRR_TICKS` consecutive ticks to pull `reset_n` low. A shorter dip has no effect. Afterwards, `reset_n` rises again after the selected delay of ticks without `vcc_low`.
- R6: The bus idles high, and this is its reset-time level. In standby, a bus level held for `WAKE_TICKS` ticks after a bus edge powers the regulator. An opposite edge restarts the measurement. A level with no preceding edge never wakes the block.
- R7: While powered, a falling edge on `en` switches the regulator off on the next clock. After a bus wake with `en` low, the regulator stays on until `en` goes high and then low.
- R8: `ovt` high switches the regulator off on the next clock and blocks any start. When `ovt` clears after a thermal shutdown, initialisation restarts whatever the levels of `en` and the bus.
- R9: `reset_n` is 0 whenever `reg_on` is 0, including directly after `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digital clock |
| rst_n | input | 1 | Asynchronous active-low reset of the digital state |
| osc_tick | input | 1 | One-clock strobe per slow-oscillator period |
| vcc_por_ok | input | 1 | Regulated rail is above the power-on threshold |
| vcc_low | input | 1 | Regulated rail is below the selected undervoltage threshold |
| en | input | 1 | Enable pin level |
| bus_lvl | input | 1 | Digitised bus level |
| ovt | input | 1 | Over-temperature flag |
| prog_lvl | input | 1 | Sensed level of the programming pin |
| reg_on | output | 1 | Regulator enable |
| reset_n | output | 1 | Active-low microcontroller reset |
| vres_hi_sel | output | 1 | Undervoltage threshold select, 1 for the high threshold |
| prog_pu | output | 1 | Pull-up strobe for the programming pin |
| prog_pd | output | 1 | Pull-down strobe for the programming pin |

## Verification
The programming pin is driven by four bench models: tied low, tied high, resistor to ground and resistor to the rail. These separate the threshold choice from the delay choice, because each model's response to the opposing strobe is known. Undervoltage dips shorter and longer than the reaction window show whether that window is counted. Bus patterns cover three cases: a long idle level with no edge, a short pulse, and a level held for the full wake width after an edge. Together they show that the wake measurement restarts on each edge. Thermal events both while powered and while in standby show that the fault takes priority over the enable pin and the bus.

// File: rtl/regwake_pkg.sv
package regwake_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PROG_SAMPLE,
    ST_PROG_PULSE,
    ST_RESET_WAIT,
    ST_ACTIVE,
    ST_THERMAL_OFF
  } rw_state_e;

  // Larger of two counts, used to size shared counters.
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Reset delay in ticks for the pin-strength result.
  function automatic int delay_ticks(input logic short_sel, input int short_t, input int long_t);
    return short_sel ? short_t : long_t;
  endfunction

  // Regulator is powered in every state except standby and thermal shutdown.
  function automatic logic state_powered(input rw_state_e s);
    return (s == ST_PROG_SAMPLE) || (s == ST_PROG_PULSE) ||
           (s == ST_RESET_WAIT) || (s == ST_ACTIVE);
  endfunction

endpackage

// File: rtl/regwake_tick_timer.sv
module regwake_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign hit    = run & tick & (cnt_nx == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || hit)   cnt_q <= '0;
    else if (tick)          cnt_q <= cnt_nx[CNT_W-1:0];
  end

  // R4 and R5: a running count never reaches its limit without firing
  assert_cnt_below_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/regwake_bus_wake.sv
module regwake_bus_wake #(
  parameter int WAKE_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic bus_lvl,
  output logic hit
);

  localparam int WK_W = (WAKE_TICKS < 2) ? 1 : $clog2(WAKE_TICKS + 1);

  logic            bus_q;
  logic            armed_q;
  logic [WK_W-1:0] age_q;
  logic            edge_seen;

  assign edge_seen = bus_lvl ^ bus_q;
  assign hit = enable & armed_q & tick & ~edge_seen &
               (age_q == WK_W'(WAKE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= 1'b1;
      armed_q <= 1'b0;
      age_q   <= '0;
    end else begin
      bus_q <= bus_lvl;
      if (!enable) begin
        armed_q <= 1'b0;
        age_q   <= '0;
      end else if (edge_seen) begin
        armed_q <= 1'b1;
        age_q   <= '0;
      end else if (hit) begin
        armed_q <= 1'b0;
        age_q   <= '0;
      end else if (tick && armed_q) begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  // R6: pulse age stays inside the wake window while armed
  assert_wake_age_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (int'(age_q) < WAKE_TICKS));

endmodule

// File: rtl/regwake_seq.sv
module regwake_seq
  import regwake_pkg::*;
#(
  parameter int LONG_TICKS  = 1600,
  parameter int SHORT_TICKS = 240,
  parameter int TRR_TICKS   = 8,
  parameter int WAKE_TICKS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic vcc_por_ok,
  input  logic vcc_low,
  input  logic en,
  input  logic bus_lvl,
  input  logic ovt,
  input  logic prog_lvl,
  output logic reg_on,
  output logic reset_n,
  output logic vres_hi_sel,
  output logic prog_pu,
  output logic prog_pd
);

  localparam int MAX_T = max_of(max_of(LONG_TICKS, SHORT_TICKS), TRR_TICKS);
  localparam int CNT_W = $clog2(MAX_T + 1);

  rw_state_e st_q, st_d;
  logic en_q, lvl_q, short_q;
  logic powered, en_fall, sample_ev, pulse_end_ev;
  logic rst_run, rst_hit, trr_run, trr_hit, wake_hit;
  logic [CNT_W-1:0] rst_limit;

  assign powered      = state_powered(st_q);
  assign en_fall      = en_q & ~en;
  assign sample_ev    = (st_q == ST_PROG_SAMPLE) && (st_d == ST_PROG_PULSE);
  assign pulse_end_ev = (st_q == ST_PROG_PULSE)  && (st_d == ST_RESET_WAIT);
  assign rst_run      = (st_q == ST_PROG_PULSE) || ((st_q == ST_RESET_WAIT) && !vcc_low);
  assign trr_run      = (st_q == ST_ACTIVE) && vcc_low;
  assign rst_limit    = CNT_W'(delay_ticks(short_q, SHORT_TICKS, LONG_TICKS));

  regwake_tick_timer #(.CNT_W(CNT_W)) rst_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .run(rst_run),
    .limit(rst_limit), .hit(rst_hit)
  );

  regwake_tick_timer #(.CNT_W(CNT_W)) trr_tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .run(trr_run),
    .limit(CNT_W'(TRR_TICKS)), .hit(trr_hit)
  );

  regwake_bus_wake #(.WAKE_TICKS(WAKE_TICKS)) wake_i (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .enable(st_q == ST_OFF),
    .bus_lvl(bus_lvl), .hit(wake_hit)
  );

  always_comb begin
    st_d = st_q;
    if (powered && ovt) begin
      st_d = ST_THERMAL_OFF;
    end else if (st_q == ST_THERMAL_OFF) begin
      if (!ovt) st_d = ST_PROG_SAMPLE;
    end else if (powered && en_fall) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:         if (!ovt && (en || wake_hit)) st_d = ST_PROG_SAMPLE;
        ST_PROG_SAMPLE: if (osc_tick && vcc_por_ok)   st_d = ST_PROG_PULSE;
        ST_PROG_PULSE:  if (osc_tick)                 st_d = ST_RESET_WAIT;
        ST_RESET_WAIT:  if (rst_hit)                  st_d = ST_ACTIVE;
        ST_ACTIVE:      if (trr_hit)                  st_d = ST_RESET_WAIT;
        default:                                      st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      en_q    <= 1'b0;
      lvl_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en;
      if (sample_ev)    lvl_q   <= prog_lvl;
      if (pulse_end_ev) short_q <= (prog_lvl != lvl_q);
    end
  end

  assign reg_on      = powered;
  assign reset_n     = (st_q == ST_ACTIVE);
  assign vres_hi_sel = lvl_q;
  assign prog_pu     = (st_q == ST_PROG_PULSE) && !lvl_q;
  assign prog_pd     = (st_q == ST_PROG_PULSE) &&  lvl_q;

  assert_start_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_on) |-> !reset_n);

  assert_vres_only_at_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vres_hi_sel) |-> $past(osc_tick && vcc_por_ok));

  assert_strobe_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_pu || prog_pd) |-> $past(osc_tick));

  assert_wake_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && !ovt) |=> reg_on);

  assert_en_fall_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_on && !ovt && en_q && !en) |=> !reg_on);

  assert_ovt_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovt |=> !reg_on);

  assert_reset_low_unpowered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_on && !$past(reg_on)) |-> !reset_n);

endmodule

// File: tb/regwake_seq_tb_top.sv
module regwake_seq_tb_top;

  localparam int L = 12;
  localparam int S = 5;
  localparam int TRR = 3;
  localparam int W = 4;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic vcc_por_ok = 1'b0, vcc_low = 1'b0, en = 1'b0, bus_lvl = 1'b1, ovt = 1'b0;
  logic prog_lvl;
  logic reg_on, reset_n, vres_hi_sel, prog_pu, prog_pd;
  int pin_mode = 0; // 0 tied low, 1 tied high, 2 resistor to low, 3 resistor to high

  always #5 clk = ~clk;

  assign prog_lvl = (pin_mode == 0) ? 1'b0 :
                    (pin_mode == 1) ? 1'b1 :
                    (pin_mode == 2) ? prog_pu : !prog_pd;

  regwake_seq #(.LONG_TICKS(L), .SHORT_TICKS(S), .TRR_TICKS(TRR), .WAKE_TICKS(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .vcc_por_ok(vcc_por_ok),
    .vcc_low(vcc_low), .en(en), .bus_lvl(bus_lvl), .ovt(ovt), .prog_lvl(prog_lvl),
    .reg_on(reg_on), .reset_n(reset_n), .vres_hi_sel(vres_hi_sel),
    .prog_pu(prog_pu), .prog_pd(prog_pd)
  );

  int checks = 0, fails = 0, cycles = 0, tdiv_cnt = 0;
  string cur_req = "R9";
  int pu_clks = 0, pd_clks = 0;

  // oscillator tick: one clock in TDIV
  always @(negedge clk) begin
    tdiv_cnt = (tdiv_cnt + 1) % TDIV;
    osc_tick = (tdiv_cnt == 0);
  end

  // behavioural reference: 0 off,1 sample,2 pulse,3 wait,4 active,5 thermal
  int m_st, nst, m_age, m_low, m_wake;
  bit m_lvl, m_short, m_en_d, m_bus_d, m_on, wake_now;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_age = 0; m_low = 0; m_wake = -1;
      m_lvl = 0; m_short = 0; m_en_d = 0; m_bus_d = 1;
    end else begin
      m_on = (m_st >= 1 && m_st <= 4);
      wake_now = 0;
      if (m_st == 0) begin
        if (bus_lvl != m_bus_d) m_wake = 0;
        else if (osc_tick && m_wake >= 0) begin
          m_wake++;
          if (m_wake == W) begin wake_now = 1; m_wake = -1; end
        end
      end else m_wake = -1;
      if (m_st != 4 || !vcc_low) m_low = 0;
      nst = m_st;
      if (m_on && ovt) nst = 5;
      else if (m_st == 5) nst = ovt ? 5 : 1;
      else if (m_on && m_en_d && !en) nst = 0;
      else case (m_st)
        0: if (!ovt && (en || wake_now)) nst = 1;
        1: if (osc_tick && vcc_por_ok) begin nst = 2; m_lvl = prog_lvl; m_age = 0; end
        2: if (osc_tick) begin nst = 3; m_short = (prog_lvl != m_lvl); m_age = 1; end
        3: if (vcc_low) m_age = 0;
           else if (osc_tick) begin
             m_age++;
             if (m_age == (m_short ? S : L)) nst = 4;
           end
        4: if (vcc_low && osc_tick) begin
             m_low++;
             if (m_low == TRR) begin nst = 3; m_age = 0; end
           end
        default: ;
      endcase
      m_st = nst;
      m_en_d = en;
      m_bus_d = bus_lvl;
    end
  end

  // compare against the reference on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (reg_on !== (m_st >= 1 && m_st <= 4) || reset_n !== (m_st == 4) ||
          vres_hi_sel !== m_lvl || prog_pu !== (m_st == 2 && !m_lvl) ||
          prog_pd !== (m_st == 2 && m_lvl)) begin
        fails++;
        $display("FAIL %s model t=%0t actual reg_on=%0b reset_n=%0b vres=%0b pu=%0b pd=%0b expected state=%0d lvl=%0b",
                 cur_req, $time, reg_on, reset_n, vres_hi_sel, prog_pu, prog_pd, m_st, m_lvl);
      end
      if (prog_pu) pu_clks++;
      if (prog_pd) pd_clks++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R9", "reg_on after reset", reg_on, 1'b0);
    chk("R9", "reset_n after reset", reset_n, 1'b0);

    // R1 R2 R3 R4: enable start, pin tied low -> low threshold, long delay
    cur_req = "R1"; pin_mode = 0; pu_clks = 0; pd_clks = 0;
    en = 1'b1; step(1);
    chk("R1", "reg_on after en", reg_on, 1'b1);
    chk("R1", "reset_n held at start", reset_n, 1'b0);
    vcc_por_ok = 1'b1; cur_req = "R4";
    ticks(S + 3);
    chk("R4", "long delay not yet done", reset_n, 1'b0);
    ticks(L);
    chk("R4", "reset_n after long delay", reset_n, 1'b1);
    chk("R2", "low threshold selected", vres_hi_sel, 1'b0);
    chk("R3", "pull-up strobe one tick", pu_clks == TDIV, 1'b1);
    chk("R3", "no pull-down strobe", pd_clks == 0, 1'b1);

    // R5: short dip ignored, long dip pulls reset
    cur_req = "R5";
    vcc_low = 1'b1; ticks(2); vcc_low = 1'b0; step(1);
    chk("R5", "short dip ignored", reset_n, 1'b1);
    vcc_low = 1'b1; ticks(TRR + 1);
    chk("R5", "long dip asserts reset", reset_n, 1'b0);
    vcc_low = 1'b0; ticks(L + 2);
    chk("R5", "reset released again", reset_n, 1'b1);

    // R7: en falling edge turns off
    cur_req = "R7";
    en = 1'b0; step(1);
    chk("R7", "off after en fall", reg_on, 1'b0);
    chk("R9", "reset low when off", reset_n, 1'b0);

    // R6: bus wake, resistor to low -> short delay, low threshold
    cur_req = "R6"; pin_mode = 2;
    ticks(10);
    chk("R6", "idle bus without edge no wake", reg_on, 1'b0);
    bus_lvl = 1'b0; ticks(2); bus_lvl = 1'b1; step(1);
    chk("R6", "short pulse no wake", reg_on, 1'b0);
    ticks(W + 1);
    chk("R6", "held level after edge wakes", reg_on, 1'b1);
    cur_req = "R4";
    ticks(S + 3);
    chk("R4", "short delay done", reset_n, 1'b1);
    chk("R2", "low threshold via resistor", vres_hi_sel, 1'b0);
    cur_req = "R7";
    ticks(10);
    chk("R7", "stays on with en low after wake", reg_on, 1'b1);
    en = 1'b1; step(2);
    chk("R7", "on while en high", reg_on, 1'b1);
    en = 1'b0; step(1);
    chk("R7", "off after en high then low", reg_on, 1'b0);

    // R8: thermal shutdown, restart regardless of en; pin resistor to high
    cur_req = "R8"; pin_mode = 3; pu_clks = 0; pd_clks = 0;
    en = 1'b1; ticks(S + 3);
    chk("R2", "high threshold selected", vres_hi_sel, 1'b1);
    chk("R3", "pull-down strobe one tick", pd_clks == TDIV, 1'b1);
    chk("R4", "short delay with resistor to high", reset_n, 1'b1);
    ovt = 1'b1; step(1);
    chk("R8", "off on over-temperature", reg_on, 1'b0);
    en = 1'b0; ticks(3);
    chk("R8", "stays off during fault", reg_on, 1'b0);
    ovt = 1'b0; step(1);
    chk("R8", "restart after fault with en low", reg_on, 1'b1);
    ticks(S + 3);
    chk("R8", "reset released after thermal restart", reset_n, 1'b1);
    en = 1'b1; step(2); en = 1'b0; step(1);
    chk("R7", "off after en pulse", reg_on, 1'b0);
    ovt = 1'b1; en = 1'b1; ticks(3);
    chk("R8", "start blocked by fault", reg_on, 1'b0);
    ovt = 1'b0; step(1);
    chk("R8", "start after fault clears", reg_on, 1'b1);
    en = 1'b0; step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule